// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

The block watches a bank of external input lines and turns chosen transitions on them into interrupt requests and one-cycle event strobes. For each line, software enables rising-edge detection, falling-edge detection, or both. Two separate masks control the interrupt path and the event path. A detected trigger on an interrupt-enabled line sets a sticky pending bit, and the line's request output stays high while that bit is set and the line is unmasked. A trigger on an event-enabled line produces a single-cycle strobe and does not touch the pending bit. Software can also raise any line directly through a software-trigger register.

Each of the low lines takes its input from the pin with the same number on one of several GPIO ports. A 2-bit port-select field per line makes the choice. The remaining high lines each have a dedicated input. Edges are captured asynchronously by toggle flops clocked by the selected pin, so a pulse shorter than a clock period is still seen. A two-flop synchronizer then brings the capture into the clock domain. Configuration and status use a plain single-cycle register write port and a combinational read port. Neither port has back-pressure, because each access completes in the cycle it is presented.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `evt_o` are all 0. There are 20 lines.
- R2: A 0-to-1 transition on a line whose rise enable (register 2, bit = line) is set, and whose interrupt enable (register 0) is set, sets that line's pending bit (register 5) within 4 clock cycles. A rising transition on a line with rise enable clear is ignored.
- R3: A 1-to-0 transition likewise sets pending when the fall enable (register 3) is set. With both rise and fall enabled, either transition triggers.
- R4: A high pulse that begins and ends between two clock edges is still detected on a line with rise enable set.
- R5: `irq_o[i]` is 1 exactly when pending bit i is set and interrupt enable bit i is set.
- R6: A trigger on a line with event enable (register 1) set produces exactly one one-cycle pulse on `evt_o` for that line. If the interrupt enable is clear, the pending bit is not set.
- R7: Writing register 5 clears each pending bit written with 1. Bits written with 0 are unchanged. A trigger in the same cycle as the clear leaves the bit set.
- R8: Writing 1 to bit i of register 4 sets software-trigger bit i and triggers line i once: pending if interrupt-enabled, a strobe if event-enabled. Rewriting a bit that is already set does not trigger again. The bit self-clears when pending bit i is cleared.
- R9: Line i (i < 16) takes `port_pins_i[p*16 + i]`, where p is the value of bits [2i+1:2i] of register 6. Lines 16 to 19 take `aux_pins_i[i-16]`.
- R10: Registers at addresses 0 to 6 read back the written value. Bits above bit 19 of registers 0 to 5 read 0. Register 6 holds all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins_i | input | 64 | Pins of 4 ports, 16 pins each; port p occupies bits [16p+15:16p] |
| aux_pins_i | input | 4 | Dedicated inputs for lines 16 to 19 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 20 | Per-line interrupt requests |
| evt_o | output | 20 | Per-line one-cycle event strobes |

## Verification
On every cycle, the checker enforces four rules:
- Requests appear only on unmasked lines.
- A pending bit rises only from an unmasked trigger in the previous cycle.
- A clear with no competing trigger empties the bit, and a competing trigger always wins.
- Event strobes appear only on event-enabled lines.

Only the bench scenarios can show the rest. That covers edge polarity selection, capture of sub-cycle pulses, port selection, the software trigger's self-clearing and the absence of a repeated trigger on rewrite. A seeded random phase compares pending and request vectors against a bench model across random pin transitions and enable patterns.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_IMASK  = 3'd0,
    A_EMASK  = 3'd1,
    A_RISE   = 3'd2,
    A_FALL   = 3'd3,
    A_SWTRIG = 3'd4,
    A_PEND   = 3'd5,
    A_PSEL   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/extint_pin_mux.sv
`timescale 1ns/1ps
module extint_pin_mux #(
  parameter int unsigned LINES     = 20,
  parameter int unsigned SEL_LINES = 16,
  parameter int unsigned SEL_W     = 2
) (
  input  logic [(2**SEL_W)*SEL_LINES-1:0] port_pins_i,
  input  logic [LINES-SEL_LINES-1:0]      aux_pins_i,
  input  logic [SEL_LINES*SEL_W-1:0]      psel_i,
  output logic [LINES-1:0]                pin_o
);
  localparam int unsigned NUM_PORTS = 2**SEL_W;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i < SEL_LINES) begin : g_sel
      logic [NUM_PORTS-1:0] cand;
      logic [SEL_W-1:0]     sel;
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign cand[p] = port_pins_i[p*SEL_LINES + i];
      end
      assign sel      = psel_i[i*SEL_W +: SEL_W];
      assign pin_o[i] = cand[sel];
    end else begin : g_aux
      assign pin_o[i] = aux_pins_i[i-SEL_LINES];
    end
  end
endmodule

// File: rtl/extint_edge_sync.sv
`timescale 1ns/1ps
module extint_edge_sync #(
  parameter int unsigned LINES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  input  logic [LINES-1:0] rise_en_i,
  input  logic [LINES-1:0] fall_en_i,
  output logic [LINES-1:0] edge_o
);
  localparam int unsigned STAGES = 3; // two synchronizer flops plus one history flop

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              tog_r, tog_f;
    logic [STAGES-1:0] sr_r, sr_f;

    // toggle capture clocked by the line itself: catches sub-cycle pulses
    always_ff @(posedge pin_i[i] or negedge rst_n) begin
      if (!rst_n)            tog_r <= 1'b0;
      else if (rise_en_i[i]) tog_r <= ~tog_r;
    end

    always_ff @(negedge pin_i[i] or negedge rst_n) begin
      if (!rst_n)            tog_f <= 1'b0;
      else if (fall_en_i[i]) tog_f <= ~tog_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sr_r <= '0;
        sr_f <= '0;
      end else begin
        sr_r <= {sr_r[STAGES-2:0], tog_r};
        sr_f <= {sr_f[STAGES-2:0], tog_f};
      end
    end

    assign edge_o[i] = (sr_r[STAGES-1] ^ sr_r[STAGES-2]) |
                       (sr_f[STAGES-1] ^ sr_f[STAGES-2]);
  end
endmodule

// File: rtl/extint_regs.sv
`timescale 1ns/1ps
module extint_regs
  import extint_pkg::*;
#(
  parameter int unsigned LINES     = 20,
  parameter int unsigned SEL_LINES = 16,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned DW        = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  input  logic [LINES-1:0]           pend_i,
  output logic [DW-1:0]              rd_data_o,
  output logic [LINES-1:0]           imask_o,
  output logic [LINES-1:0]           emask_o,
  output logic [LINES-1:0]           rise_o,
  output logic [LINES-1:0]           fall_o,
  output logic [SEL_LINES*SEL_W-1:0] psel_o,
  output logic [LINES-1:0]           sw_pulse_o,
  output logic [LINES-1:0]           pend_clr_o
);
  localparam int unsigned PSEL_W = SEL_LINES*SEL_W;

  logic [LINES-1:0]  imask_q, emask_q, rise_q, fall_q, swtrig_q;
  logic [PSEL_W-1:0] psel_q;
  logic [LINES-1:0]  sw_set;

  assign sw_set     = (wr_en_i && wr_addr_i == A_SWTRIG) ? wr_data_i[LINES-1:0] : '0;
  assign pend_clr_o = (wr_en_i && wr_addr_i == A_PEND)   ? wr_data_i[LINES-1:0] : '0;
  assign sw_pulse_o = sw_set & ~swtrig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      psel_q  <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_IMASK: imask_q <= wr_data_i[LINES-1:0];
        A_EMASK: emask_q <= wr_data_i[LINES-1:0];
        A_RISE:  rise_q  <= wr_data_i[LINES-1:0];
        A_FALL:  fall_q  <= wr_data_i[LINES-1:0];
        A_PSEL:  psel_q  <= wr_data_i[PSEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swtrig_q <= '0;
    else        swtrig_q <= (swtrig_q | sw_set) & ~pend_clr_o;
  end

  always_comb begin
    case (rd_addr_i)
      A_IMASK:  rd_data_o = DW'(imask_q);
      A_EMASK:  rd_data_o = DW'(emask_q);
      A_RISE:   rd_data_o = DW'(rise_q);
      A_FALL:   rd_data_o = DW'(fall_q);
      A_SWTRIG: rd_data_o = DW'(swtrig_q);
      A_PEND:   rd_data_o = DW'(pend_i);
      A_PSEL:   rd_data_o = DW'(psel_q);
      default:  rd_data_o = '0;
    endcase
  end

  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign psel_o  = psel_q;
endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/1ps
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned LINES     = 20,
  parameter int unsigned SEL_LINES = 16,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned DW        = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [(2**SEL_W)*SEL_LINES-1:0]    port_pins_i,
  input  logic [LINES-SEL_LINES-1:0]         aux_pins_i,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [DW-1:0]                      wr_data_i,
  input  logic [ADDR_W-1:0]                  rd_addr_i,
  output logic [DW-1:0]                      rd_data_o,
  output logic [LINES-1:0]                   irq_o,
  output logic [LINES-1:0]                   evt_o
);
  localparam int unsigned PSEL_W = SEL_LINES*SEL_W;

  logic [LINES-1:0]  imask_v, emask_v, rise_v, fall_v;
  logic [PSEL_W-1:0] psel_v;
  logic [LINES-1:0]  sw_pulse_v, pend_clr_v, pin_v, edge_v, trig_v;
  logic [LINES-1:0]  pend_q, evt_q;

  extint_regs #(.LINES(LINES), .SEL_LINES(SEL_LINES), .SEL_W(SEL_W), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .pend_i(pend_q), .rd_data_o(rd_data_o),
    .imask_o(imask_v), .emask_o(emask_v), .rise_o(rise_v), .fall_o(fall_v),
    .psel_o(psel_v), .sw_pulse_o(sw_pulse_v), .pend_clr_o(pend_clr_v)
  );

  extint_pin_mux #(.LINES(LINES), .SEL_LINES(SEL_LINES), .SEL_W(SEL_W)) mux_i (
    .port_pins_i(port_pins_i), .aux_pins_i(aux_pins_i),
    .psel_i(psel_v), .pin_o(pin_v)
  );

  extint_edge_sync #(.LINES(LINES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_v),
    .rise_en_i(rise_v), .fall_en_i(fall_v), .edge_o(edge_v)
  );

  assign trig_v = edge_v | sw_pulse_v;

  // a new trigger outranks a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr_v) | (trig_v & imask_v);
      evt_q  <= trig_v & emask_v;
    end
  end

  assign irq_o = pend_q & imask_v;
  assign evt_o = evt_q;
endmodule

// File: rtl/extint_ctrl_chk.sv
`timescale 1ns/1ps
module extint_ctrl_chk #(
  parameter int unsigned LINES = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] imask,
  input logic [LINES-1:0] emask,
  input logic [LINES-1:0] trig,
  input logic [LINES-1:0] pend_clr,
  input logic [LINES-1:0] pend_q,
  input logic [LINES-1:0] irq_o,
  input logic [LINES-1:0] evt_o
);
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~imask) == '0);

  assert_pend_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(trig & imask)) == '0));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_clr & ~trig)) == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend_q & $past(trig & imask)) == '0));

  assert_evt_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_o & ~$past(emask)) == '0));
endmodule

bind extint_ctrl extint_ctrl_chk #(.LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .imask(imask_v), .emask(emask_v),
  .trig(trig_v), .pend_clr(pend_clr_v), .pend_q(pend_q),
  .irq_o(irq_o), .evt_o(evt_o)
);

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
module extint_ctrl_tb_top;
  import extint_pkg::*;

  localparam int L = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pp = '0;
  logic [3:0]  ax = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [L-1:0] irq, evt;

  int checks = 0, errors = 0;
  int evt_cnt [L];
  bit done = 1'b0;

  always #5 clk = ~clk;

  extint_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .port_pins_i(pp), .aux_pins_i(ax),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .evt_o(evt)
  );

  always @(negedge clk) if (rst_n) for (int i = 0; i < L; i++) if (evt[i]) evt_cnt[i]++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req, input string what);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, what, d, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_evt();
    for (int i = 0; i < L; i++) evt_cnt[i] = 0;
  endtask

  function automatic logic [L-1:0] line_vals(input logic [63:0] p, input logic [3:0] a,
                                             input logic [31:0] ps);
    logic [L-1:0] v;
    for (int i = 0; i < L; i++)
      v[i] = (i < 16) ? p[int'(ps[2*i +: 2])*16 + i] : a[i-16];
    return v;
  endfunction

  function automatic logic [L-1:0] exp_trig(input logic [L-1:0] o, input logic [L-1:0] n,
                                            input logic [L-1:0] r, input logic [L-1:0] f);
    return (~o & n & r) | (o & ~n & f);
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, psel_r;
    logic [L-1:0] o, n, rise, fall, im, e;
    void'($urandom(32'd20240611));
    clr_evt();
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 32'h0, "R1", "reset register");
    chk(irq == '0 && evt == '0, "R1", "reset outputs", {irq[15:0], evt[15:0]}, 32'h0);

    // R10 readback and unused bits
    wr(A_IMASK, 32'hFFFF_FFFF); rd_chk(A_IMASK, 32'h000F_FFFF, "R10", "imask width");
    wr(A_FALL, 32'h0005_A5A5);  rd_chk(A_FALL, 32'h0005_A5A5, "R10", "fall readback");
    wr(A_PSEL, 32'hDEAD_BEEF);  rd_chk(A_PSEL, 32'hDEAD_BEEF, "R10", "psel readback");
    wr(A_PSEL, 0); wr(A_FALL, 0); wr(A_IMASK, 0);

    // R2 rising edge, and a disabled falling edge
    wr(A_RISE, 1 << 3); wr(A_IMASK, 1 << 3);
    @(negedge clk); pp[3] = 1'b1; wait_cyc(6);
    chk(irq[3] == 1'b1, "R2", "rise irq", 32'(irq[3]), 32'h1);
    rd_chk(A_PEND, 1 << 3, "R2", "rise pending");
    wr(A_PEND, 1 << 3);
    @(negedge clk); pp[3] = 1'b0; wait_cyc(6);
    rd_chk(A_PEND, 0, "R2", "fall ignored without enable");

    // R3 falling-only line, both-edge line
    wr(A_FALL, (1 << 17) | (1 << 5)); wr(A_RISE, (1 << 5) | (1 << 3));
    wr(A_IMASK, (1 << 17) | (1 << 5) | (1 << 3));
    @(negedge clk); ax[1] = 1'b1; wait_cyc(6);
    rd_chk(A_PEND, 0, "R3", "rise ignored on fall-only line");
    @(negedge clk); ax[1] = 1'b0; pp[5] = 1'b1; wait_cyc(6);
    rd_chk(A_PEND, (1 << 17) | (1 << 5), "R3", "fall and rise");
    wr(A_PEND, 1 << 5);
    @(negedge clk); pp[5] = 1'b0; wait_cyc(6);
    rd_chk(A_PEND, (1 << 17) | (1 << 5), "R3", "both-edge line on fall");
    wr(A_PEND, 32'hF_FFFF);

    // R4 sub-cycle pulse
    wr(A_RISE, 1 << 7); wr(A_FALL, 0); wr(A_IMASK, 1 << 7);
    @(negedge clk); pp[7] = 1'b1; #2; pp[7] = 1'b0;
    wait_cyc(6);
    rd_chk(A_PEND, 1 << 7, "R4", "short pulse captured");
    wr(A_PEND, 32'hF_FFFF);

    // R6 event mode
    wr(A_RISE, 1 << 9); wr(A_IMASK, 0); wr(A_EMASK, 1 << 9); clr_evt();
    @(negedge clk); pp[9] = 1'b1; wait_cyc(6);
    chk(evt_cnt[9] == 1, "R6", "one event strobe", 32'(evt_cnt[9]), 32'h1);
    rd_chk(A_PEND, 0, "R6", "event mode leaves pending clear");
    chk(irq == '0, "R6", "no irq in event mode", 32'(irq), 32'h0);
    @(negedge clk); pp[9] = 1'b0; wr(A_EMASK, 0);

    // R7 write-one-to-clear, zero writes, set wins
    wr(A_RISE, 1 << 3); wr(A_FALL, 1 << 3); wr(A_IMASK, 1 << 3);
    @(negedge clk); pp[3] = 1'b1; wait_cyc(6);
    wr(A_PEND, 0);
    rd_chk(A_PEND, 1 << 3, "R7", "zero write keeps pending");
    @(negedge clk); pp[3] = 1'b0;
    @(negedge clk);
    wr(A_PEND, 1 << 3); // lands on the same edge as the trigger
    rd_chk(A_PEND, 1 << 3, "R7", "set wins over clear");
    wait_cyc(4);
    wr(A_PEND, 1 << 3);
    rd_chk(A_PEND, 0, "R7", "clear");
    chk(irq == '0, "R5", "irq drops with pending", 32'(irq), 32'h0);

    // R8 software trigger
    wr(A_IMASK, 1 << 12); wr(A_EMASK, (1 << 12) | (1 << 13)); clr_evt();
    wr(A_SWTRIG, (1 << 12) | (1 << 13));
    rd_chk(A_SWTRIG, (1 << 12) | (1 << 13), "R8", "swtrig bits set");
    rd_chk(A_PEND, 1 << 12, "R8", "swtrig pends only unmasked line");
    wr(A_SWTRIG, 1 << 12); wait_cyc(2);
    chk(evt_cnt[12] == 1 && evt_cnt[13] == 1, "R8", "single strobe per line",
        32'(evt_cnt[12] * 16 + evt_cnt[13]), 32'h11);
    rd_chk(A_PEND, 1 << 12, "R8", "rewrite adds nothing");
    wr(A_PEND, (1 << 12) | (1 << 13));
    rd_chk(A_SWTRIG, 0, "R8", "swtrig self-clears");
    wr(A_EMASK, 0);

    // R9 port selection
    wr(A_PSEL, 32'(2) << 8); wr(A_RISE, 1 << 4); wr(A_FALL, 0); wr(A_IMASK, 1 << 4);
    @(negedge clk); pp[0*16 + 4] = 1'b1; wait_cyc(6);
    rd_chk(A_PEND, 0, "R9", "unselected port ignored");
    @(negedge clk); pp[2*16 + 4] = 1'b1; wait_cyc(6);
    rd_chk(A_PEND, 1 << 4, "R9", "selected port triggers");
    @(negedge clk); pp = '0; wait_cyc(6);
    wr(A_PEND, 32'hF_FFFF);

    // random phase (R2, R3, R5)
    psel_r = $urandom;
    wr(A_PSEL, psel_r);
    for (int it = 0; it < 40; it++) begin
      rise = L'($urandom); fall = L'($urandom); im = L'($urandom);
      wr(A_RISE, 32'(rise)); wr(A_FALL, 32'(fall)); wr(A_IMASK, 32'(im));
      wr(A_PEND, 32'hF_FFFF);
      o = line_vals(pp, ax, psel_r);
      @(negedge clk); pp = {$urandom, $urandom}; ax = 4'($urandom);
      n = line_vals(pp, ax, psel_r);
      e = exp_trig(o, n, rise, fall) & im;
      wait_cyc(6);
      rd(A_PEND, d);
      chk(d == 32'(e), "R2", "random pending (R3 edges)", d, 32'(e));
      chk(irq == e, "R5", "random irq", 32'(irq), 32'(e));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule